// File: doc/BRIEF.md
# SIMD Thread-Group Issue Scheduler

This block sits in front of one 16-lane SIMD shader array. The array shares one program counter across all lanes, so in any cycle it runs the same instruction for a single thread group of 16 work items. Those items are either 16 vertices or four 2x2 pixel quads. The scheduler holds a small pool of thread-group contexts. Each context has its own program counter and a vertex/pixel tag. Every clock the scheduler picks one ready context and presents its slot number, tag and program counter on the issue port. Instruction fetch and the lanes then act on that one group.

Successive instructions of one group have no bypass path between them. A group that has just issued therefore stalls for the full fixed pipeline latency. Other ready groups fill those cycles. Vertex and pixel groups interleave freely with no switch cost, so the type mix over time follows the loaded work.

Each context slot runs its own small state machine with three states:
- `SLOT_EMPTY`: the slot holds no context. A load moves it to `SLOT_ARMED`.
- `SLOT_ARMED`: the context is ready to issue.
  - If it is granted with the end flag high, it goes back to `SLOT_EMPTY`.
  - If it is granted without the end flag, it goes to `SLOT_STALLED` and its down-counter is loaded with latency minus one.
- `SLOT_STALLED`: the counter counts down, and at the count of one the slot returns to `SLOT_ARMED`.

The instruction-end flag arrives in the same cycle as the issue it belongs to.

Top module: `issue_scheduler`

## Requirements
- R1: At most one context issues per cycle. `issue_slot`, `issue_kind` and `issue_pc` are the slot number, tag and current program counter of that one context.
- R2: After reset all slots are empty, `issue_valid` and `retire_valid` are low and both issue counters read zero.
- R3: A context that issues in cycle t without the end flag does not issue again before cycle t+LATENCY. It is ready again in cycle t+LATENCY.
- R4: A load sets the context's program counter to `load_pc`. Each issue without the end flag advances it by one.
- R5: In a cycle with no ready context, `issue_valid` is low (an idle bubble).
- R6: Among ready contexts, the one chosen is the first found when searching upward from the slot after the last issued slot, wrapping from NUM_CTX-1 to 0. Before any issue, the search starts at slot 0.
- R7: The tag (`load_kind` 0 = vertex, 1 = pixel) plays no part in selection. Switching between vertex and pixel groups costs no cycle.
- R8: An issue with `end_of_program` high frees the slot. One cycle later `retire_valid` pulses with `retire_slot` equal to that slot, and the slot does not issue again until it is reloaded.
- R9: A load into an empty slot may occur in the same cycle as an issue from another slot. The loaded context is ready in the next cycle.
- R10: `vtx_issues` and `pix_issues` count the valid issues with tag 0 and tag 1 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Load a new context this cycle |
| load_slot | input | $clog2(NUM_CTX) | Target slot, which must be empty |
| load_kind | input | 1 | 0 = vertex group, 1 = pixel group |
| load_pc | input | PC_W | Start program counter |
| issue_valid | output | 1 | A context issues this cycle |
| issue_slot | output | $clog2(NUM_CTX) | Issuing slot |
| issue_kind | output | 1 | Tag of the issuing group |
| issue_pc | output | PC_W | Program counter sent to all lanes |
| end_of_program | input | 1 | The instruction issuing this cycle is the last of its program |
| retire_valid | output | 1 | A context was freed in the previous cycle |
| retire_slot | output | $clog2(NUM_CTX) | Slot that was freed |
| vtx_issues | output | CNT_W | Count of vertex issues |
| pix_issues | output | CNT_W | Count of pixel issues |

## Verification
The assertions assume two things about the inputs: a load only targets an empty slot, and `end_of_program` is meaningful only while `issue_valid` is high. The stimulus keeps to both by tracking slot occupancy itself. It reloads a slot only after observing its retirement, and it drives the end flag solely from the program length it assigned to the issuing group. The sweep runs from one to eight contexts under several vertex/pixel mixes and program lengths, with reloads in mid-run. This exercises idle bubbles, wrap-around of the round-robin search, and latency stalls.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic {
        KIND_VTX = 1'b0,
        KIND_PIX = 1'b1
    } work_kind_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_ARMED   = 2'd1,
        SLOT_STALLED = 2'd2
    } slot_state_e;
endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
    import sched_pkg::*;
#(
    parameter int LATENCY = 6,
    parameter int PC_W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  work_kind_e      load_kind,
    input  logic [PC_W-1:0] load_pc,
    input  logic            grant,
    input  logic            last_instr,
    output logic            ready,
    output logic            occupied,
    output work_kind_e      kind,
    output logic [PC_W-1:0] pc
);
    localparam int LAT_W = $clog2(LATENCY + 1);

    slot_state_e     state_q, state_d;
    logic [LAT_W-1:0] cnt_q, cnt_d;
    logic [PC_W-1:0] pc_q, pc_d;
    work_kind_e      kind_q, kind_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            cnt_q   <= '0;
            pc_q    <= '0;
            kind_q  <= KIND_VTX;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pc_q    <= pc_d;
            kind_q  <= kind_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pc_d    = pc_q;
        kind_d  = kind_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (load_en) begin
                    state_d = SLOT_ARMED;
                    pc_d    = load_pc;
                    kind_d  = load_kind;
                end
            end
            SLOT_ARMED: begin
                if (grant) begin
                    if (last_instr) begin
                        state_d = SLOT_EMPTY;
                    end else begin
                        pc_d = pc_q + 1'b1;
                        if (LATENCY > 1) begin
                            state_d = SLOT_STALLED;
                            cnt_d   = LAT_W'(LATENCY - 1);
                        end
                    end
                end
            end
            SLOT_STALLED: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == LAT_W'(1)) state_d = SLOT_ARMED;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        ready    = (state_q == SLOT_ARMED);
        occupied = (state_q != SLOT_EMPTY);
        kind     = kind_q;
        pc       = pc_q;
    end

    // Independent gap tracker for the latency property.
    logic [LAT_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 gap_q <= LAT_W'(LATENCY);
        else if (load_en)           gap_q <= LAT_W'(LATENCY);
        else if (grant)             gap_q <= LAT_W'(1);
        else if (gap_q < LAT_W'(LATENCY)) gap_q <= gap_q + 1'b1;
    end

    assert_latency_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> gap_q >= LAT_W'(LATENCY));

    assert_grant_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> state_q == SLOT_ARMED);

    assert_load_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> state_q == SLOT_EMPTY);

    assert_retired_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && last_instr) |=> !ready);
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int NUM_CTX = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CTX-1:0]         ready,
    output logic [NUM_CTX-1:0]         grant,
    output logic                       any,
    output logic [$clog2(NUM_CTX)-1:0] idx
);
    localparam int IDW = $clog2(NUM_CTX);

    logic [IDW-1:0] last_q;

    always_comb begin
        int cand;
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int off = 1; off <= NUM_CTX; off++) begin
            cand = int'(last_q) + off;
            if (cand >= NUM_CTX) cand = cand - NUM_CTX;
            if (!any && ready[cand]) begin
                any = 1'b1;
                idx = IDW'(cand);
            end
        end
        if (any) grant[idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   last_q <= IDW'(NUM_CTX - 1);
        else if (any) last_q <= idx;
    end

    assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_bubble_only_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> ready == '0);

    assert_grant_is_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ready[idx]);
endmodule

// File: rtl/issue_counters.sv
module issue_counters
    import sched_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  work_kind_e       kind,
    output logic [CNT_W-1:0] vtx_cnt,
    output logic [CNT_W-1:0] pix_cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtx_cnt <= '0;
            pix_cnt <= '0;
        end else if (fire) begin
            if (kind == KIND_PIX) pix_cnt <= pix_cnt + 1'b1;
            else                  vtx_cnt <= vtx_cnt + 1'b1;
        end
    end

    assert_pix_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && kind == KIND_PIX) |=> (pix_cnt == $past(pix_cnt) + 1'b1) && $stable(vtx_cnt));

    assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(pix_cnt) && $stable(vtx_cnt));
endmodule

// File: rtl/issue_scheduler.sv
module issue_scheduler
    import sched_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int LATENCY = 6,
    parameter int PC_W    = 8,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_valid,
    input  logic [$clog2(NUM_CTX)-1:0] load_slot,
    input  logic                       load_kind,
    input  logic [PC_W-1:0]            load_pc,
    output logic                       issue_valid,
    output logic [$clog2(NUM_CTX)-1:0] issue_slot,
    output logic                       issue_kind,
    output logic [PC_W-1:0]            issue_pc,
    input  logic                       end_of_program,
    output logic                       retire_valid,
    output logic [$clog2(NUM_CTX)-1:0] retire_slot,
    output logic [CNT_W-1:0]           vtx_issues,
    output logic [CNT_W-1:0]           pix_issues
);
    localparam int IDW = $clog2(NUM_CTX);

    logic [NUM_CTX-1:0] ready, occupied, grant;
    work_kind_e         kind_arr [NUM_CTX];
    logic [PC_W-1:0]    pc_arr   [NUM_CTX];
    logic               any;
    logic [IDW-1:0]     idx;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
        ctx_slot #(.LATENCY(LATENCY), .PC_W(PC_W)) i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_en    (load_valid && (load_slot == IDW'(g))),
            .load_kind  (work_kind_e'(load_kind)),
            .load_pc    (load_pc),
            .grant      (grant[g]),
            .last_instr (end_of_program),
            .ready      (ready[g]),
            .occupied   (occupied[g]),
            .kind       (kind_arr[g]),
            .pc         (pc_arr[g])
        );
    end

    rr_picker #(.NUM_CTX(NUM_CTX)) i_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready),
        .grant (grant),
        .any   (any),
        .idx   (idx)
    );

    always_comb begin
        issue_valid = any;
        issue_slot  = idx;
        issue_kind  = any ? logic'(kind_arr[idx]) : 1'b0;
        issue_pc    = any ? pc_arr[idx] : '0;
    end

    issue_counters #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (any),
        .kind    (work_kind_e'(issue_kind)),
        .vtx_cnt (vtx_issues),
        .pix_cnt (pix_issues)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retire_valid <= 1'b0;
            retire_slot  <= '0;
        end else begin
            retire_valid <= any && end_of_program;
            retire_slot  <= idx;
        end
    end

    assert_retired_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> !(issue_valid && issue_slot == retire_slot));

    assert_retired_freed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> !occupied[retire_slot]);
endmodule

// File: tb/test_issue_scheduler.sv
module test_issue_scheduler;
    localparam int N   = 8;
    localparam int L   = 6;
    localparam int PCW = 8;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_valid = 1'b0;
    logic [2:0]     load_slot = '0;
    logic           load_kind = 1'b0;
    logic [PCW-1:0] load_pc = '0;
    logic           end_of_program = 1'b0;
    logic           issue_valid, issue_kind, retire_valid;
    logic [2:0]     issue_slot, retire_slot;
    logic [PCW-1:0] issue_pc;
    logic [CW-1:0]  vtx_issues, pix_issues;

    always #5 clk = ~clk;

    issue_scheduler #(.NUM_CTX(N), .LATENCY(L), .PC_W(PCW), .CNT_W(CW)) i_issue_scheduler (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_slot(load_slot),
        .load_kind(load_kind), .load_pc(load_pc), .issue_valid(issue_valid),
        .issue_slot(issue_slot), .issue_kind(issue_kind), .issue_pc(issue_pc),
        .end_of_program(end_of_program), .retire_valid(retire_valid),
        .retire_slot(retire_slot), .vtx_issues(vtx_issues), .pix_issues(pix_issues)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // model of the requirements
    bit m_live [N];
    bit m_kind [N];
    int m_pc   [N];
    int m_end  [N];
    int m_ok   [N];
    int obs_last [N];
    int last_id;
    bit exp_ret;
    int exp_ret_slot;
    int exp_vtx, exp_pix;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One clock: sample at negedge, compare, drive, update model.
    task automatic step(input bit do_load, input int ls, input bit lk, input int lpc, input int llen);
        bit ev;
        int ec;
        bit done;
        @(negedge clk);
        ev = 1'b0;
        ec = 0;
        for (int off = 1; off <= N; off++) begin
            int c;
            c = (last_id + off) % N;
            if (!ev && m_live[c] && cyc >= m_ok[c]) begin
                ev = 1'b1;
                ec = c;
            end
        end
        check(issue_valid == ev, "R5 issue_valid", int'(issue_valid), int'(ev));
        if (ev && issue_valid) begin
            check(int'(issue_slot) == ec, "R1/R6 issue_slot", int'(issue_slot), ec);
            check(issue_kind == m_kind[ec], "R7 issue_kind", int'(issue_kind), int'(m_kind[ec]));
            check(int'(issue_pc) == m_pc[ec], "R4/R9 issue_pc", int'(issue_pc), m_pc[ec]);
        end
        if (issue_valid) begin
            if (obs_last[issue_slot] >= 0)
                check(cyc - obs_last[issue_slot] >= L, "R3 reissue gap",
                      cyc - obs_last[issue_slot], L);
            obs_last[issue_slot] = cyc;
        end
        check(retire_valid == exp_ret, "R8 retire_valid", int'(retire_valid), int'(exp_ret));
        if (exp_ret && retire_valid)
            check(int'(retire_slot) == exp_ret_slot, "R8 retire_slot", int'(retire_slot), exp_ret_slot);

        done = ev && (m_pc[ec] == m_end[ec]);
        end_of_program = done;
        load_valid     = do_load;
        load_slot      = 3'(ls);
        load_kind      = lk;
        load_pc        = PCW'(lpc);

        exp_ret = 1'b0;
        if (ev) begin
            if (done) begin
                m_live[ec]   = 1'b0;
                exp_ret      = 1'b1;
                exp_ret_slot = ec;
            end else begin
                m_pc[ec] = m_pc[ec] + 1;
                m_ok[ec] = cyc + L;
            end
            last_id = ec;
        end
        if (do_load) begin
            m_live[ls]   = 1'b1;
            m_kind[ls]   = lk;
            m_pc[ls]     = lpc;
            m_end[ls]    = lpc + llen - 1;
            m_ok[ls]     = cyc + 1;
            obs_last[ls] = -1;
            if (lk) exp_pix += llen; else exp_vtx += llen;
        end
        cyc++;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_live[i] = 0; m_kind[i] = 0; m_pc[i] = 0; m_end[i] = 0; m_ok[i] = 0; obs_last[i] = -1;
        end
        last_id = N - 1;
        exp_ret = 0; exp_ret_slot = 0; exp_vtx = 0; exp_pix = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state before any load
        @(negedge clk);
        check(issue_valid == 1'b0, "R2 issue_valid", int'(issue_valid), 0);
        check(retire_valid == 1'b0, "R2 retire_valid", int'(retire_valid), 0);
        check(vtx_issues == 0 && pix_issues == 0, "R2 counters",
              int'(vtx_issues) + int'(pix_issues), 0);

        for (int n = 1; n <= N; n++) begin
            for (int mix = 0; mix < 3; mix++) begin
                int loaded;
                int reloads;
                int guard;
                bit busy;
                loaded  = 0;
                reloads = 2;
                guard   = 0;
                busy    = 1'b1;
                while (busy && guard < 3000) begin
                    guard++;
                    if (loaded < n) begin
                        bit k;
                        k = (mix == 2) ? 1'b0 : 1'(((loaded + mix) % 2));
                        step(1'b1, loaded, k, 16 * loaded + n,
                             1 + ((loaded * 3 + n + mix) % 5));
                        loaded++;
                    end else if (exp_ret && reloads > 0) begin
                        // R9: reload a freed slot while others keep issuing
                        reloads--;
                        step(1'b1, exp_ret_slot, !m_kind[exp_ret_slot],
                             130 + 8 * exp_ret_slot, 3);
                    end else begin
                        step(1'b0, 0, 1'b0, 0, 0);
                    end
                    busy = 1'b0;
                    for (int s = 0; s < N; s++) if (m_live[s]) busy = 1'b1;
                    if (loaded < n) busy = 1'b1;
                end
                check(guard < 3000, "R8 all retired", guard, 0);
                // drain trailing retire pulse and check bubble
                step(1'b0, 0, 1'b0, 0, 0);
                step(1'b0, 0, 1'b0, 0, 0);
                check(int'(vtx_issues) == exp_vtx, "R10 vtx_issues", int'(vtx_issues), exp_vtx);
                check(int'(pix_issues) == exp_pix, "R10 pix_issues", int'(pix_issues), exp_pix);
            end
        end
        load_valid = 1'b0;
        end_of_program = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule